// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block supervises a host processor by watching traffic on a two-wire serial bus. The host does not need a separate kick line. The block passes the clock and data lines through two-flop synchronizers. It then detects start conditions (data falling while the clock is high) and stop conditions (data rising while the clock is high). The countdown restarts whenever the bus shows a start, then a clock low phase, then a clock high phase, and then a stop. The block decodes no other part of the protocol. Any complete read or write transaction contains this pattern.

A millisecond tick input provides the time base. A 2-bit period code selects a short, medium or long period, or turns the watchdog off. The default periods are 25, 200 and 1400 ticks. If the selected period runs out with no restart, the watchdog output rises. It stays high until the next valid bus sequence clears it and reloads the count.

Top module: `buswd_top`

## Requirements
- R1: After reset the watchdog output `wdo` is low and the tick count is zero.
- R2: The period code on `period_sel` selects the limit: 0 gives `LIM_SHORT` ticks, 1 gives `LIM_MID` and 2 gives `LIM_LONG`. `wdo` rises on the tick that completes the limit after a restart, and not on any earlier tick.
- R3: Once `wdo` is high, further ticks leave it high until a restart.
- R4: A start, then a clock low phase, then a clock high phase, then a stop clears `wdo` and restarts the count from zero. Any number of clock pulses may come between the start and the stop.
- R5: A start followed directly by a stop, with no clock low and high phases, does not restart the watchdog. Data changes while the clock is low are neither starts nor stops.
- R6: Period code 3 forces `wdo` low and holds the count at zero. Leaving code 3 begins a full new period.
- R7: A change of `period_sel` restarts the count, and the new limit applies from that point.
- R8: Cycles without `ms_tick` do not advance the count.
- R9: A repeated start before the stop re-arms the pattern tracking. A stop that follows such a start directly does not restart the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond of time base |
| scl_in | input | 1 | Serial bus clock line, asynchronous |
| sda_in | input | 1 | Serial bus data line, asynchronous |
| period_sel | input | 2 | Period code: 0 short, 1 medium, 2 long, 3 off |
| wdo | output | 1 | Watchdog expired, active high |

## Verification
Every enabled period code is swept tick by tick past its limit. This separates an early expiry, a late expiry and a wrong limit for each code. The bus is driven with four kinds of pattern. The first is the minimal restart sequence. The second is a longer transaction with data bits, which shows that extra clock pulses are tolerated. The third is a start-stop pair with no clock phases, and the fourth is data toggling while the clock is low. These last two tell a true restart apart from a line that merely moves. A repeated-start pattern checks that the tracker re-arms. Separate runs change the period code in mid-count and switch to the off code, and leave gaps with no tick. These runs separate a restart from a simple continuation of the count.

// File: rtl/buswd_pkg.sv
package buswd_pkg;
  typedef enum logic [1:0] {
    SEL_SHORT = 2'd0,
    SEL_MID   = 2'd1,
    SEL_LONG  = 2'd2,
    SEL_OFF   = 2'd3
  } wd_sel_e;

  typedef enum logic [1:0] {
    TRK_IDLE  = 2'd0,
    TRK_START = 2'd1,
    TRK_LOW   = 2'd2,
    TRK_HIGH  = 2'd3
  } trk_state_e;
endpackage

// File: rtl/buswd_sync.sv
module buswd_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // idle bus lines are high, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_in;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/buswd_seq.sv
module buswd_seq
  import buswd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic kick
);
  logic       scl_q, sda_q;
  trk_state_e state_q, state_n;
  logic       bus_start, bus_stop, scl_fall, scl_rise;

  assign bus_start = scl & scl_q & sda_q & ~sda;
  assign bus_stop  = scl & scl_q & ~sda_q & sda;
  assign scl_fall  = scl_q & ~scl;
  assign scl_rise  = ~scl_q & scl;

  always_comb begin
    state_n = state_q;
    kick    = 1'b0;
    if (bus_start) begin
      state_n = TRK_START;
    end else if (bus_stop) begin
      kick    = (state_q == TRK_HIGH);
      state_n = TRK_IDLE;
    end else begin
      unique case (state_q)
        TRK_START: if (scl_fall) state_n = TRK_LOW;
        TRK_LOW:   if (scl_rise) state_n = TRK_HIGH;
        default:   state_n = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      state_q <= TRK_IDLE;
    end else begin
      scl_q   <= scl;
      sda_q   <= sda;
      state_q <= state_n;
    end
  end

  // R4
  kick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (state_q == TRK_IDLE));

  // R9
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (state_q == TRK_START));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TRK_IDLE && !bus_start) |=> (state_q == TRK_IDLE));
endmodule

// File: rtl/buswd_timer.sv
module buswd_timer
  import buswd_pkg::*;
#(
  parameter int LIM_SHORT = 25,
  parameter int LIM_MID   = 200,
  parameter int LIM_LONG  = 1400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       kick,
  input  logic [1:0] period_sel,
  output logic       wdo
);
  localparam int LIM_MAX = (LIM_LONG > LIM_MID) ?
                           ((LIM_LONG > LIM_SHORT) ? LIM_LONG : LIM_SHORT) :
                           ((LIM_MID > LIM_SHORT) ? LIM_MID : LIM_SHORT);
  localparam int CW = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_n, cnt_inc, limit;
  logic          wdo_q, wdo_n;
  logic [1:0]    sel_q;
  logic          sel_chg, is_off;

  assign sel_chg = (period_sel != sel_q);
  assign is_off  = (period_sel == SEL_OFF);
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    unique case (period_sel)
      SEL_SHORT: limit = CW'(LIM_SHORT);
      SEL_MID:   limit = CW'(LIM_MID);
      SEL_LONG:  limit = CW'(LIM_LONG);
      default:   limit = '0;
    endcase
  end

  always_comb begin
    cnt_n = cnt_q;
    wdo_n = wdo_q;
    if (is_off || kick || sel_chg) begin
      cnt_n = '0;
      wdo_n = 1'b0;
    end else if (ms_tick && !wdo_q) begin
      cnt_n = cnt_inc;
      wdo_n = (cnt_inc == limit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wdo_q <= 1'b0;
      sel_q <= SEL_OFF;
    end else begin
      cnt_q <= cnt_n;
      wdo_q <= wdo_n;
      sel_q <= period_sel;
    end
  end

  assign wdo = wdo_q;

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_off |=> (!wdo_q && cnt_q == '0));

  // R4
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!wdo_q && cnt_q == '0));

  // R3
  wdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdo_q && !kick && !sel_chg && !is_off) |=> wdo_q);

  // R8
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_tick && !kick && !sel_chg && !is_off) |=> $stable(cnt_q));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_chg && !is_off) |-> (cnt_q <= limit));
endmodule

// File: rtl/buswd_top.sv
module buswd_top #(
  parameter int LIM_SHORT = 25,
  parameter int LIM_MID   = 200,
  parameter int LIM_LONG  = 1400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] period_sel,
  output logic       wdo
);
  logic [1:0] lines_sync;
  logic       kick;

  buswd_sync #(.W(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   ({scl_in, sda_in}),
    .d_sync (lines_sync)
  );

  buswd_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .scl   (lines_sync[1]),
    .sda   (lines_sync[0]),
    .kick  (kick)
  );

  buswd_timer #(
    .LIM_SHORT (LIM_SHORT),
    .LIM_MID   (LIM_MID),
    .LIM_LONG  (LIM_LONG)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .kick       (kick),
    .period_sel (period_sel),
    .wdo        (wdo)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> !wdo);
endmodule

// File: tb/tb_buswd_top.sv
module tb_buswd_top;
  localparam int CLK_PERIOD = 10;
  localparam int L0 = 4;
  localparam int L1 = 7;
  localparam int L2 = 11;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ms_tick;
  logic       scl_in, sda_in;
  logic [1:0] period_sel;
  logic       wdo;

  int checks = 0;
  int failures = 0;

  buswd_top #(.LIM_SHORT(L0), .LIM_MID(L1), .LIM_LONG(L2)) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .scl_in(scl_in),
    .sda_in(sda_in), .period_sel(period_sel), .wdo(wdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: wdo actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic bus(input logic c, input logic d);
    @(negedge clk); scl_in = c; sda_in = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic restart_seq();
    bus(1, 0); bus(0, 0); bus(1, 0); bus(1, 1);
  endtask

  function automatic int lim_of(input int s);
    return (s == 0) ? L0 : (s == 1) ? L1 : L2;
  endfunction

  task automatic expire_short();
    period_sel = 2'd0;
    restart_seq();
    repeat (L0) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
    period_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk(wdo, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(wdo, 1'b0, "R1 after reset");

    // R2 and R3: sweep each enabled code tick by tick past its limit
    for (int s = 0; s < 3; s++) begin
      period_sel = s[1:0];
      restart_seq();
      chk(wdo, 1'b0, "R4 restart before sweep");
      for (int n = 1; n <= lim_of(s) + 3; n++) begin
        tick();
        chk(wdo, n >= lim_of(s), (n > lim_of(s)) ? "R3 hold" : "R2 expiry");
      end
    end

    // R4 minimal sequence clears an expired watchdog
    expire_short();
    chk(wdo, 1'b1, "R2 expired short");
    restart_seq();
    chk(wdo, 1'b0, "R4 minimal clear");
    repeat (L0 - 1) tick();
    chk(wdo, 1'b0, "R4 count from zero");
    tick();
    chk(wdo, 1'b1, "R4 full period");

    // R4 longer transaction with data bits
    bus(1, 0); bus(0, 0); bus(0, 1); bus(1, 1); bus(0, 1);
    bus(0, 0); bus(1, 0); bus(0, 0); bus(1, 0); bus(1, 1);
    chk(wdo, 1'b0, "R4 long transaction");

    // R5 start then stop only
    expire_short();
    bus(1, 0); bus(1, 1);
    chk(wdo, 1'b1, "R5 start-stop ignored");
    // R5 data toggles with clock low
    bus(0, 1); bus(0, 0); bus(0, 1); bus(1, 1);
    chk(wdo, 1'b1, "R5 data under low clock");

    // R9 repeated start then stop
    bus(1, 0); bus(0, 0); bus(0, 1); bus(1, 1); bus(1, 0); bus(1, 1);
    chk(wdo, 1'b1, "R9 repeated start rearm");
    restart_seq();
    chk(wdo, 1'b0, "R9 then valid restart");

    // R8 gaps without tick
    period_sel = 2'd1;
    restart_seq();
    repeat (L1 - 2) tick();
    repeat (40) @(negedge clk);
    chk(wdo, 1'b0, "R8 idle gap");
    tick();
    chk(wdo, 1'b0, "R8 one short");
    tick();
    chk(wdo, 1'b1, "R8 exact after gap");

    // R7 code change restarts with new limit
    period_sel = 2'd0;
    restart_seq();
    repeat (L0 - 1) tick();
    @(negedge clk); period_sel = 2'd2;
    @(negedge clk);
    repeat (L2 - 1) tick();
    chk(wdo, 1'b0, "R7 new limit minus one");
    tick();
    chk(wdo, 1'b1, "R7 new limit");
    @(negedge clk); period_sel = 2'd1;
    @(negedge clk);
    chk(wdo, 1'b0, "R7 change clears");

    // R6 off code
    expire_short();
    @(negedge clk); period_sel = 2'd3;
    @(negedge clk);
    chk(wdo, 1'b0, "R6 off clears");
    repeat (L2 + 3) tick();
    chk(wdo, 1'b0, "R6 off no expiry");
    @(negedge clk); period_sel = 2'd0;
    @(negedge clk);
    repeat (L0 - 1) tick();
    chk(wdo, 1'b0, "R6 leave off fresh count");
    tick();
    chk(wdo, 1'b1, "R6 full period after off");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule